// File: doc/BRIEF.md
# Calibrated Thermal Threshold Monitor

This block supervises die temperature from an 8-bit raw sensor code. A command through its 32-bit register port loads a 16-bit fused trim word and checks it. The block keeps the checked trim value and derives from it a set of threshold codes that include the trim offset. The raw code is compared against those stored codes, so the compare path needs no per-sample arithmetic.

Alongside the comparisons, the block converts each sample to degrees Celsius and sorts it into one of four classes: normal, warning, tripped or uninitialised. A reading outside the plausible range drops the unit back to the uninitialised class until the next trim load. Crossings of each threshold, upward and downward, latch sticky flags. The flags are cleared by writing ones, and an enable mask selects which of them raise the interrupt output. A separate sticky trip output is meant for a power controller's emergency shutdown.

Register words (index on `reg_addr`): 0 control, 1 trim command / effective trim, 2 packed thresholds, 3 interrupt enable, 4 interrupt flags, 5 status.

Top module: `thermo_monitor`

## Requirements
- R1: After a synchronous reset, the control word reads 0x10008802. The interrupt enable reads 0x00000110, flags read 0 and status reads 0. `irq` and `trip` are low. The first cycle after reset never counts as a threshold crossing.
- R2: Writing word 1 with bit 0 set captures `trim_word`. Bits [7:0] become te1 and bits [15:8] are te2. If te1 < 40, te1 > 100 or te2 != 0, the effective te1 is 55; otherwise it is te1. Word 1 reads the effective te1 in [7:0]. A write to word 1 with bit 0 clear changes nothing. The default after reset is 55.
- R3: Word 2 reads {hw, trip, warn, 8'h00}. Each byte is its limit + te1 - 25 (mod 256), with the limits hw = 110, trip = 105 and warn = 95.
- R4: Status bits [15:8] hold the low 8 bits of (code - te1 + 25), sampled each cycle. A code of 0 reports 0.
- R5: While initialised, status bits [1:0] classify the Celsius value c. The class is 3 (tripped) for 105 <= c <= 125. Otherwise it is 2 (warning) for c >= 95, and otherwise 1 (normal) for c >= 25.
- R6: Any other value of c clears the initialised bit (status bit 16) and forces the class to 0. The unit stays there until the next trim load, which sets the bit again. While uninitialised, the class is 0.
- R7: The rising flag of level k (threshold byte k, k = 0..2) is set when the code moves from below that byte to at or above it. Its flag bit is 4k.
- R8: The falling flag of level k is set when the code moves from at or above its threshold byte to below it. Its flag bit is 16 + 4k.
- R9: Writing word 4 clears each flag whose bit is written as 1. If a flag is cleared and newly set in the same cycle, the set wins.
- R10: `irq` rises one cycle after a flag. It equals control bit 0 (core enable) AND the OR of the flags masked by word 3. Word 3 keeps only the six flag positions.
- R11: `trip` is set when control bits 0 and 12 are both 1 and the code is at or above threshold byte 3. It stays high until reset.
- R12: `reg_rdata` is registered: it shows the word addressed at the previous clock edge. Indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| sensor_code | input | 8 | Raw temperature code |
| trim_word | input | 16 | Fused trim word |
| irq | output | 1 | Interrupt request |
| trip | output | 1 | Sticky hardware thermal trip |

## Verification
Two events can land on the same clock edge: a threshold crossing that sets a flag, and a write-one-to-clear aimed at that flag. The bench holds the code one step below the warning threshold. At one falling edge it moves the code onto the threshold and also issues a clear of that flag's bit. It then reads the flag word and expects the bit still set. A second clear with no crossing must then empty it. A trim load that coincides with an out-of-range reading is a second collision: the sweeps reload before each sample, and the bench judges that the load wins.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  typedef enum logic [1:0] {
    CLS_UNINIT = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_WARN   = 2'd2,
    CLS_TRIP   = 2'd3
  } therm_class_e;

  localparam int WORD_CTRL  = 0;
  localparam int WORD_TRIM  = 1;
  localparam int WORD_THR   = 2;
  localparam int WORD_IEN   = 3;
  localparam int WORD_FLAG  = 4;
  localparam int WORD_STAT  = 5;

endpackage

// File: rtl/thermo_trim.sv
module thermo_trim #(
  parameter int CODE_W   = 8,
  parameter int TE_MIN   = 40,
  parameter int TE_MAX   = 100,
  parameter int TE_DEF   = 55,
  parameter int OFFSET   = 25,
  parameter int LIM_WARN = 95,
  parameter int LIM_TRIP = 105,
  parameter int LIM_HW   = 110
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reload,
  input  logic [2*CODE_W-1:0]   trim_word,
  output logic [CODE_W-1:0]     te1_q,
  output logic [4*CODE_W-1:0]   thr_q
);

  localparam logic [CODE_W-1:0] WARN_OFS = CODE_W'(LIM_WARN - OFFSET);
  localparam logic [CODE_W-1:0] TRIP_OFS = CODE_W'(LIM_TRIP - OFFSET);
  localparam logic [CODE_W-1:0] HW_OFS   = CODE_W'(LIM_HW - OFFSET);
  localparam logic [CODE_W-1:0] TE_DEF_C = CODE_W'(TE_DEF);

  logic [CODE_W-1:0]   raw_lo, raw_hi, te_new;
  logic                bad;

  function automatic logic [4*CODE_W-1:0] pack_thr(input logic [CODE_W-1:0] te);
    return {te + HW_OFS, te + TRIP_OFS, te + WARN_OFS, {CODE_W{1'b0}}};
  endfunction

  always_comb begin
    raw_lo = trim_word[CODE_W-1:0];
    raw_hi = trim_word[2*CODE_W-1:CODE_W];
    bad    = (raw_lo < CODE_W'(TE_MIN)) || (raw_lo > CODE_W'(TE_MAX)) || (raw_hi != '0);
    te_new = bad ? TE_DEF_C : raw_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      te1_q <= TE_DEF_C;
      thr_q <= pack_thr(TE_DEF_C);
    end else if (reload) begin
      te1_q <= te_new;
      thr_q <= pack_thr(te_new);
    end
  end

endmodule

// File: rtl/thermo_classify.sv
module thermo_classify
  import thermo_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int OFFSET   = 25,
  parameter int LIM_MIN  = 25,
  parameter int LIM_WARN = 95,
  parameter int LIM_TRIP = 105,
  parameter int LIM_MAX  = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] te1,
  output therm_class_e      class_q,
  output logic [CODE_W-1:0] cel_q,
  output logic              init_q
);

  localparam int SW = CODE_W + 2;

  logic signed [SW-1:0] cel;
  therm_class_e         cls;
  logic                 fail;

  always_comb begin
    if (code == '0) cel = '0;
    else cel = signed'({2'b00, code}) - signed'({2'b00, te1}) + signed'(SW'(OFFSET));
    fail = 1'b0;
    cls  = CLS_UNINIT;
    if (cel >= signed'(SW'(LIM_TRIP)) && cel <= signed'(SW'(LIM_MAX))) cls = CLS_TRIP;
    else if (cel >= signed'(SW'(LIM_WARN)))                            cls = CLS_WARN;
    else if (cel >= signed'(SW'(LIM_MIN)))                             cls = CLS_NORMAL;
    else                                                               fail = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= 1'b0;
      class_q <= CLS_UNINIT;
      cel_q   <= '0;
    end else begin
      cel_q   <= cel[CODE_W-1:0];
      class_q <= (init_q && !fail) ? cls : CLS_UNINIT;
      if (reload)    init_q <= 1'b1;
      else if (fail) init_q <= 1'b0;
    end
  end

endmodule

// File: rtl/thermo_irq.sv
module thermo_irq #(
  parameter int CODE_W = 8,
  parameter int N_LVL  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CODE_W-1:0]         code,
  input  logic [(N_LVL+1)*CODE_W-1:0] thr,
  input  logic                      core_en,
  input  logic                      trip_en,
  input  logic [N_LVL-1:0]          clr_rise,
  input  logic [N_LVL-1:0]          clr_fall,
  input  logic [N_LVL-1:0]          ien_rise,
  input  logic [N_LVL-1:0]          ien_fall,
  output logic [N_LVL-1:0]          rise_q,
  output logic [N_LVL-1:0]          fall_q,
  output logic                      irq_q,
  output logic                      trip_q
);

  wire  [N_LVL-1:0] above;
  logic [N_LVL-1:0] above_q;
  logic             primed_q;
  logic             hw_hit;

  for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
    assign above[k] = code >= thr[k*CODE_W +: CODE_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        rise_q[k] <= 1'b0;
        fall_q[k] <= 1'b0;
      end else begin
        rise_q[k] <= (primed_q & above[k] & ~above_q[k]) | (rise_q[k] & ~clr_rise[k]);
        fall_q[k] <= (primed_q & ~above[k] & above_q[k]) | (fall_q[k] & ~clr_fall[k]);
      end
    end
  end

  assign hw_hit = code >= thr[N_LVL*CODE_W +: CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q  <= '0;
      primed_q <= 1'b0;
      irq_q    <= 1'b0;
      trip_q   <= 1'b0;
    end else begin
      above_q  <= above;
      primed_q <= 1'b1;
      irq_q    <= core_en & (|((rise_q & ien_rise) | (fall_q & ien_fall)));
      trip_q   <= trip_q | (core_en & trip_en & hw_hit);
    end
  end

endmodule

// File: rtl/thermo_monitor.sv
module thermo_monitor
  import thermo_pkg::*;
#(
  parameter int          CODE_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 3,
  parameter int          N_LVL       = 3,
  parameter int          RISE_BASE   = 0,
  parameter int          FALL_BASE   = 16,
  parameter int          FLAG_STRIDE = 4,
  parameter int          CORE_BIT    = 0,
  parameter int          TRIPEN_BIT  = 12,
  parameter logic [31:0] CTRL_RESET  = 32'h1000_8802,
  parameter logic [31:0] IEN_RESET   = 32'h0000_0110
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [CODE_W-1:0]   sensor_code,
  input  logic [2*CODE_W-1:0] trim_word,
  output logic                irq,
  output logic                trip
);

  localparam int STAT_CEL = 8;
  localparam int STAT_INI = 16;

  logic [DATA_W-1:0]         ctrl_q;
  logic [N_LVL-1:0]          ien_r_q, ien_f_q;
  logic [N_LVL-1:0]          clr_r, clr_f, rise_q, fall_q;
  logic [CODE_W-1:0]         te1_q, cel_q;
  logic [(N_LVL+1)*CODE_W-1:0] thr_q;
  logic                      init_q;
  therm_class_e              class_q;
  logic [DATA_W-1:0]         flags, ien_vec, stat_vec, rd_next;
  logic                      wr_trim, wr_flag, wr_ien, reload;

  assign wr_trim = reg_we && (reg_addr == ADDR_W'(WORD_TRIM));
  assign wr_flag = reg_we && (reg_addr == ADDR_W'(WORD_FLAG));
  assign wr_ien  = reg_we && (reg_addr == ADDR_W'(WORD_IEN));
  assign reload  = wr_trim && reg_wdata[0];

  always_comb begin
    flags   = '0;
    ien_vec = '0;
    for (int k = 0; k < N_LVL; k++) begin
      clr_r[k] = wr_flag & reg_wdata[RISE_BASE + FLAG_STRIDE*k];
      clr_f[k] = wr_flag & reg_wdata[FALL_BASE + FLAG_STRIDE*k];
      flags[RISE_BASE + FLAG_STRIDE*k]   = rise_q[k];
      flags[FALL_BASE + FLAG_STRIDE*k]   = fall_q[k];
      ien_vec[RISE_BASE + FLAG_STRIDE*k] = ien_r_q[k];
      ien_vec[FALL_BASE + FLAG_STRIDE*k] = ien_f_q[k];
    end
    stat_vec = '0;
    stat_vec[1:0] = class_q;
    stat_vec[STAT_CEL +: CODE_W] = cel_q;
    stat_vec[STAT_INI] = init_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      for (int k = 0; k < N_LVL; k++) begin
        ien_r_q[k] <= IEN_RESET[RISE_BASE + FLAG_STRIDE*k];
        ien_f_q[k] <= IEN_RESET[FALL_BASE + FLAG_STRIDE*k];
      end
    end else begin
      if (reg_we && reg_addr == ADDR_W'(WORD_CTRL)) ctrl_q <= reg_wdata;
      if (wr_ien) begin
        for (int k = 0; k < N_LVL; k++) begin
          ien_r_q[k] <= reg_wdata[RISE_BASE + FLAG_STRIDE*k];
          ien_f_q[k] <= reg_wdata[FALL_BASE + FLAG_STRIDE*k];
        end
      end
    end
  end

  always_comb begin
    case (int'(reg_addr))
      WORD_CTRL: rd_next = ctrl_q;
      WORD_TRIM: rd_next = {{(DATA_W-CODE_W){1'b0}}, te1_q};
      WORD_THR:  rd_next = DATA_W'(thr_q);
      WORD_IEN:  rd_next = ien_vec;
      WORD_FLAG: rd_next = flags;
      WORD_STAT: rd_next = stat_vec;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  thermo_trim #(.CODE_W(CODE_W)) trim_i (
    .clk(clk), .rst(rst), .reload(reload), .trim_word(trim_word),
    .te1_q(te1_q), .thr_q(thr_q)
  );

  thermo_classify #(.CODE_W(CODE_W)) cls_i (
    .clk(clk), .rst(rst), .reload(reload), .code(sensor_code), .te1(te1_q),
    .class_q(class_q), .cel_q(cel_q), .init_q(init_q)
  );

  thermo_irq #(.CODE_W(CODE_W), .N_LVL(N_LVL)) irq_i (
    .clk(clk), .rst(rst), .code(sensor_code), .thr(thr_q),
    .core_en(ctrl_q[CORE_BIT]), .trip_en(ctrl_q[TRIPEN_BIT]),
    .clr_rise(clr_r), .clr_fall(clr_f), .ien_rise(ien_r_q), .ien_fall(ien_f_q),
    .rise_q(rise_q), .fall_q(fall_q), .irq_q(irq), .trip_q(trip)
  );

endmodule

// File: rtl/thermo_monitor_chk.sv
module thermo_monitor_chk #(
  parameter int CODE_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int FLAG_WORD = 4,
  parameter int TE_MIN    = 40,
  parameter int TE_MAX    = 100
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              irq,
  input logic              trip,
  input logic              core_en,
  input logic              init_q,
  input logic [1:0]        class_q,
  input logic [DATA_W-1:0] flags,
  input logic [CODE_W-1:0] te1
);

  p_trip_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    trip |=> trip);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    !core_en |=> !irq);

  p_uninit_class_r6: assert property (@(posedge clk) disable iff (rst)
    !init_q |-> (class_q == 2'd0));

  p_te1_window_r2: assert property (@(posedge clk) disable iff (rst)
    (te1 >= CODE_W'(TE_MIN)) && (te1 <= CODE_W'(TE_MAX)));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == ADDR_W'(FLAG_WORD)) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind thermo_monitor thermo_monitor_chk chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .irq(irq), .trip(trip), .core_en(ctrl_q[0]), .init_q(init_q),
  .class_q(class_q), .flags(flags), .te1(te1_q)
);

// File: tb/thermo_monitor_tb_top.sv
module thermo_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  sensor_code = '0;
  logic [15:0] trim_word = '0;
  logic        irq, trip;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  thermo_monitor dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sensor_code(sensor_code),
    .trim_word(trim_word), .irq(irq), .trip(trip)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  function automatic int eff_te(input logic [15:0] tw);
    if (tw[7:0] < 40 || tw[7:0] > 100 || tw[15:8] != 0) return 55;
    return int'(tw[7:0]);
  endfunction

  function automatic logic [31:0] exp_thr(input int te);
    logic [7:0] w, t, h;
    w = 8'(95 + te - 25); t = 8'(105 + te - 25); h = 8'(110 + te - 25);
    return {h, t, w, 8'h00};
  endfunction

  function automatic logic [31:0] exp_stat(input int code, input int te, input bit was_init);
    int c; logic [1:0] cls; bit ok;
    c = (code == 0) ? 0 : code - te + 25;
    ok = 1'b1;
    if (c >= 105 && c <= 125) cls = 2'd3;
    else if (c >= 95) cls = 2'd2;
    else if (c >= 25) cls = 2'd1;
    else begin cls = 2'd0; ok = 1'b0; end
    if (!was_init) cls = 2'd0;
    return {15'd0, ok & was_init, 8'(c), 6'd0, cls};
  endfunction

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R1 trip in reset", {31'd0, trip}, 32'd0);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    tick();
    rd(3'd0, d); check("R1 control reset", d, 32'h1000_8802);
    rd(3'd3, d); check("R1 enable reset", d, 32'h0000_0110);
    rd(3'd4, d); check("R1 flags reset, no first-cycle crossing", d, 32'd0);
    rd(3'd5, d); check("R1 status reset", d, 32'd0);
    rd(3'd1, d); check("R2 default trim", d, 32'd55);
    rd(3'd2, d); check("R3 default thresholds", d, exp_thr(55));
    rd(3'd6, d); check("R12 unmapped word 6", d, 32'd0);
    rd(3'd7, d); check("R12 unmapped word 7", d, 32'd0);

    // R2/R3 sweep over every te1 with te2 = 0, plus nonzero te2 cases
    for (int t = 0; t < 256; t++) begin
      trim_word = 16'(t);
      wr(3'd1, 32'd1);
      rd(3'd1, d); check("R2 effective te1", d, 32'(eff_te(16'(t))));
      rd(3'd2, d); check("R3 packed thresholds", d, exp_thr(eff_te(16'(t))));
    end
    foreach (trim_word[i]) begin
      if (i >= 8) begin
        trim_word = 16'h0046 | (16'h1 << i);
        wr(3'd1, 32'd1);
        rd(3'd1, d); check("R2 te2 nonzero forces default", d, 32'd55);
      end
    end
    trim_word = 16'h0046;
    wr(3'd1, 32'd1);
    trim_word = 16'h0030;
    wr(3'd1, 32'd0);
    rd(3'd1, d); check("R2 write without reload bit ignored", d, 32'd70);

    // R4/R5/R6 sweep: reload then sample every code for three trims
    foreach (d[i]) begin
      int te;
      if (i > 2) continue;
      te = (i == 0) ? 40 : (i == 1) ? 55 : 100;
      for (int code = 0; code < 256; code++) begin
        sensor_code = 8'(code);
        trim_word = 16'(te);
        wr(3'd1, 32'd1);
        tick();
        rd(3'd5, d);
        check("R4 R5 R6 status after reload", d, exp_stat(code, te, 1'b1));
      end
    end
    // R6: failure sticks until reload
    trim_word = 16'd55;
    sensor_code = 8'd100;
    wr(3'd1, 32'd1);
    sensor_code = 8'd10;
    tick(); tick();
    sensor_code = 8'd105;
    tick(); tick();
    rd(3'd5, d); check("R6 uninitialised persists", d, exp_stat(105, 55, 1'b0));
    wr(3'd1, 32'd1);
    tick();
    rd(3'd5, d); check("R6 reload restores class", d, exp_stat(105, 55, 1'b1));

    // Flags: te1 = 55 gives thresholds 125, 135, 140
    sensor_code = 8'd100; tick(); tick();
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); check("R9 clear all", d, 32'd0);
    sensor_code = 8'd124; tick(); tick();
    sensor_code = 8'd125; tick(); tick();
    rd(3'd4, d); check("R7 rise level1", d, 32'h0000_0010);
    check("R10 irq off without core enable", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'h1000_8803);
    tick();
    check("R10 irq with core enable", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h0000_0010);
    tick();
    check("R10 irq drops after clear", {31'd0, irq}, 32'd0);
    rd(3'd4, d); check("R9 single clear", d, 32'd0);
    sensor_code = 8'd135; tick(); tick();
    rd(3'd4, d); check("R7 rise level2", d, 32'h0000_0100);
    check("R10 irq from rise2", {31'd0, irq}, 32'd1);
    sensor_code = 8'd124; tick(); tick();
    rd(3'd4, d); check("R8 fall levels 1 and 2", d, 32'h0110_0100);
    wr(3'd4, 32'hFFFF_FFFF);
    tick();
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R10 enable mask keeps flag bits", d, 32'h0111_0111);
    wr(3'd3, 32'h0010_0000);
    sensor_code = 8'd125; tick(); tick();
    check("R10 rise1 masked", {31'd0, irq}, 32'd0);
    sensor_code = 8'd124; tick(); tick();
    check("R8 R10 fall1 raises irq", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'hFFFF_FFFF);
    // R9 collision: crossing and clear on the same edge
    sensor_code = 8'd125;
    wr(3'd4, 32'h0000_0010);
    rd(3'd4, d); check("R9 set wins over clear", d, 32'h0000_0010);
    wr(3'd4, 32'h0000_0010);
    rd(3'd4, d); check("R9 later clear", d, 32'd0);

    // Trip
    sensor_code = 8'd140; tick(); tick();
    check("R11 no trip without trip enable", {31'd0, trip}, 32'd0);
    sensor_code = 8'd0; tick();
    wr(3'd0, 32'h1000_9803);
    sensor_code = 8'd139; tick(); tick();
    check("R11 below hw threshold", {31'd0, trip}, 32'd0);
    sensor_code = 8'd140; tick();
    check("R11 trip asserts", {31'd0, trip}, 32'd1);
    sensor_code = 8'd0;
    wr(3'd0, 32'd0);
    tick(); tick();
    check("R11 trip sticky", {31'd0, trip}, 32'd1);
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick();
    check("R11 trip cleared by reset", {31'd0, trip}, 32'd0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule